// File: doc/BRIEF.md
# Single-Register Two-Wire Configuration Slave

This block is a two-wire serial slave that lets a bus host write or read one 8-bit configuration register. There is no register sub-address: after a START, the host sends a 7-bit device address and a direction bit. If the address matches, the slave acknowledges. A write then carries data bytes straight into the register. A read returns the register contents.

Both bus lines are sampled with a fast system clock. A persistence filter removes short spikes on each line. START and STOP are recognised on the filtered lines.

The device address comes from a parameter table. Two three-level strap inputs select the entry, and they are sampled once when reset is released. SDA is driven open-drain through an output-enable pin. The register value, a register-load strobe, an end-of-acknowledge pulse and an end-of-write pulse go to the surrounding configuration logic.

Top module: `i2c1r_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Clock pulses that arrive without a preceding START get no acknowledge.
- R2: After a START, the first 8 bits are sampled on SCL rising edges, MSB first: 7 address bits, then R/W (0 = write, 1 = read). On a match the slave pulls SDA low for the 9th clock. On a mismatch it leaves SDA released until the next START.
- R3: Each strap input is a 2-bit code: 00 = tied low, 01 = tied high, 10 = open. The table entry index is (rank of strap_a)*3 + (rank of strap_b), where low=0, high=1 and open=2. In each 8-bit entry, bit 7 is the valid flag and bits 6:0 are the address. The straps are latched in the first cycle after reset, and later strap changes have no effect. With the default table, open/open selects 0x60 and low/low selects 0x68.
- R4: A table entry whose valid bit is 0 (default: strap_a open, strap_b high), or a strap code of 11, makes the slave acknowledge no address at all.
- R5: In a write, the 8 data bits are shifted in MSB first. When SCL falls after the 8th bit, the byte is loaded into cfg_q, wr_stb pulses for one cycle in that same cycle, and the slave acknowledges the byte.
- R6: Further data bytes in the same write each overwrite cfg_q in turn.
- R7: In a read, the slave drives the register MSB first, starting at the SCL fall that ends the address acknowledge. If the host acknowledges, the slave sends the register again. If the host does not acknowledge, the slave releases SDA.
- R8: A START or STOP in the middle of a transfer ends it at once, and a partly received byte is discarded. A START also begins a new address phase.
- R9: A level on SCL or SDA that lasts fewer than FILT_CNT system clocks (default 5, i.e. 50 ns at 100 MHz) is ignored.
- R10: Reset sets cfg_q to REG_RST (default 0xE1: scale 256, 32 kHz, outputs enabled) and releases SDA.
- R11: At the SCL fall that ends a slave-driven acknowledge, ack_done pulses for one cycle. When that acknowledge follows a write data byte, wr_done pulses in the same cycle.
- R12: The slave starts pulling SDA low only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_a | input | 2 | First three-level address strap (00 low, 01 high, 10 open) |
| strap_b | input | 2 | Second three-level address strap |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| cfg_q | output | DATA_W | Current configuration register value |
| wr_stb | output | 1 | One-cycle pulse when cfg_q is loaded |
| wr_done | output | 1 | One-cycle pulse at the end of a write data acknowledge |
| ack_done | output | 1 | One-cycle pulse at the end of any slave acknowledge |

## Verification
A pad edge reaches the filtered lines after two synchroniser flops plus FILT_CNT cycles, about 8 cycles at the default setting. The slave's SDA drive therefore changes roughly 8 to 9 cycles after an SCL fall. The bench holds each SCL phase for 40 cycles and samples SDA two cycles before lowering SCL, well after every drive change has settled. cfg_q and wr_stb change in the same cycle, so the monitor compares cfg_q on the falling clock edge of the cycle in which wr_stb is seen. The wr_done and ack_done pulses are counted against the number of acknowledged bytes and addresses, and each pulse is checked to last exactly one cycle.

// File: rtl/i2c1r_pkg.sv
package i2c1r_pkg;

  localparam int ADDR_W   = 7;
  localparam int N_LVL    = 3;
  localparam int N_ENTRY  = N_LVL * N_LVL;
  localparam int ENTRY_W  = ADDR_W + 1;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_HIGH = 2'b01;
  localparam logic [1:0] LVL_OPEN = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } slv_state_e;

  // rank of a strap code; 3 marks an illegal code
  function automatic logic [1:0] lvl_rank(input logic [1:0] code);
    case (code)
      LVL_LOW:  lvl_rank = 2'd0;
      LVL_HIGH: lvl_rank = 2'd1;
      LVL_OPEN: lvl_rank = 2'd2;
      default:  lvl_rank = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/i2c1r_glitch_filter.sv
module i2c1r_glitch_filter #(
  parameter int   FILT_CNT = 5,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  localparam int CW = $clog2(FILT_CNT + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_d;

  always_comb begin
    cnt_d = '0;
    out_d = dout;
    if (sync_q[1] != dout) begin
      if (cnt_q == CW'(FILT_CNT - 1)) begin
        out_d = sync_q[1];
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{RST_VAL}};
      cnt_q  <= '0;
      dout   <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], din};
      cnt_q  <= cnt_d;
      dout   <= out_d;
    end
  end

  // R9: the filtered level only moves to a value the synchronised input held for two cycles
  a_r9_filter_persist: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> ($past(sync_q[1]) == dout && $past(sync_q[1], 2) == dout));

endmodule

// File: rtl/i2c1r_bus_events.sv
module i2c1r_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;

  // R1: bus conditions and clock edges never coincide
  a_r1_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall, start_ev, stop_ev}));

endmodule

// File: rtl/i2c1r_strap_addr.sv
module i2c1r_strap_addr
  import i2c1r_pkg::*;
#(
  parameter logic [N_ENTRY*ENTRY_W-1:0] ADDR_TABLE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_a,
  input  logic [1:0]        strap_b,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              addr_ok
);

  logic [1:0]         ra, rb;
  logic [3:0]         idx;
  logic [ENTRY_W-1:0] entry;
  logic               codes_ok;
  logic               latched_q;

  always_comb begin
    ra       = lvl_rank(strap_a);
    rb       = lvl_rank(strap_b);
    codes_ok = (ra != 2'd3) && (rb != 2'd3);
    idx      = {2'b00, ra} * 4'd3 + {2'b00, rb};
    entry    = '0;
    for (int k = 0; k < N_ENTRY; k++) begin
      if (idx == 4'(k)) entry = ADDR_TABLE[k*ENTRY_W +: ENTRY_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched_q <= 1'b0;
      dev_addr  <= '0;
      addr_ok   <= 1'b0;
    end else if (!latched_q) begin
      latched_q <= 1'b1;
      dev_addr  <= entry[ADDR_W-1:0];
      addr_ok   <= entry[ENTRY_W-1] & codes_ok;
    end
  end

  // R3: once latched, the strap-derived address never moves
  a_r3_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && $past(latched_q)) |-> ($stable(dev_addr) && $stable(addr_ok)));

endmodule

// File: rtl/i2c1r_slave.sv
module i2c1r_slave
  import i2c1r_pkg::*;
#(
  parameter int                          FILT_CNT   = 5,
  parameter int                          DATA_W     = 8,
  parameter logic [DATA_W-1:0]           REG_RST    = 8'hE1,
  parameter logic [N_ENTRY*ENTRY_W-1:0]  ADDR_TABLE = {8'hE0, 8'h00, 8'hE4, 8'hE2, 8'hF4,
                                                       8'hF1, 8'hE3, 8'hF0, 8'hE8}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        strap_a,
  input  logic [1:0]        strap_b,
  output logic              sda_oe,
  output logic [DATA_W-1:0] cfg_q,
  output logic              wr_stb,
  output logic              wr_done,
  output logic              ack_done
);

  localparam int SH_W   = (DATA_W > ADDR_W) ? DATA_W : ADDR_W + 1;
  localparam int CNT_W  = $clog2(SH_W + 1);
  localparam int A_BITS = ADDR_W + 1;

  logic [1:0] raw, flt;
  logic       scl_f, sda_f;
  logic       scl_rise, scl_fall, start_ev, stop_ev;
  logic [ADDR_W-1:0] dev_addr;
  logic       addr_ok;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_flt
    i2c1r_glitch_filter #(.FILT_CNT(FILT_CNT), .RST_VAL(1'b1)) u_flt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw[g]),
      .dout (flt[g])
    );
  end

  assign scl_f = flt[0];
  assign sda_f = flt[1];

  i2c1r_bus_events u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  i2c1r_strap_addr #(.ADDR_TABLE(ADDR_TABLE)) u_strap (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_a (strap_a),
    .strap_b (strap_b),
    .dev_addr(dev_addr),
    .addr_ok (addr_ok)
  );

  slv_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic [DATA_W-1:0] tx_q, tx_d, reg_d;
  logic              rw_q, rw_d, mack_q, mack_d, oe_d;
  logic              wstb_d, wdone_d, adone_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    oe_d    = sda_oe;
    reg_d   = cfg_q;
    wstb_d  = 1'b0;
    wdone_d = 1'b0;
    adone_d = 1'b0;
    if (stop_ev) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (start_ev) begin
      st_d  = ST_ADDR;
      oe_d  = 1'b0;
      cnt_d = '0;
      sh_d  = '0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[SH_W-2:0], sda_f};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_W'(A_BITS)) begin
            if (addr_ok && sh_q[ADDR_W:1] == dev_addr) begin
              st_d = ST_AACK;
              oe_d = 1'b1;
              rw_d = sh_q[0];
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            adone_d = 1'b1;
            cnt_d   = '0;
            if (rw_q) begin
              st_d = ST_RDAT;
              tx_d = cfg_q;
              oe_d = ~cfg_q[DATA_W-1];
            end else begin
              st_d = ST_WDAT;
              oe_d = 1'b0;
            end
          end
        end
        ST_WDAT: begin
          if (scl_rise) begin
            sh_d  = {sh_q[SH_W-2:0], sda_f};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_W'(DATA_W)) begin
            reg_d  = sh_q[DATA_W-1:0];
            wstb_d = 1'b1;
            oe_d   = 1'b1;
            st_d   = ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            adone_d = 1'b1;
            wdone_d = 1'b1;
            cnt_d   = '0;
            st_d    = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall) begin
            if (cnt_q == CNT_W'(DATA_W)) begin
              oe_d = 1'b0;
              st_d = ST_RACK;
            end else begin
              tx_d = {tx_q[DATA_W-2:0], 1'b0};
              oe_d = ~tx_q[DATA_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_f;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_d  = ST_RDAT;
              tx_d  = cfg_q;
              oe_d  = ~cfg_q[DATA_W-1];
              cnt_d = '0;
            end else begin
              st_d = ST_IDLE;
              oe_d = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      sda_oe   <= 1'b0;
      cfg_q    <= REG_RST;
      wr_stb   <= 1'b0;
      wr_done  <= 1'b0;
      ack_done <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      tx_q     <= tx_d;
      rw_q     <= rw_d;
      mack_q   <= mack_d;
      sda_oe   <= oe_d;
      cfg_q    <= reg_d;
      wr_stb   <= wstb_d;
      wr_done  <= wdone_d;
      ack_done <= adone_d;
    end
  end

  // R12: the slave begins pulling SDA only while SCL is low
  a_r12_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  // R4: with no usable address the slave never drives the bus
  a_r4_silent_unmatched: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ok |-> !sda_oe);

  // R5: the register moves only together with its load strobe
  a_r5_reg_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q != $past(cfg_q)) |-> wr_stb);

  // R11: the end-of-write pulse closes a driven acknowledge and lasts one cycle
  a_r11_wr_done_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> ($past(sda_oe) && !sda_oe && ack_done));

  a_r11_wr_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

endmodule

// File: tb/sim_i2c1r_slave.sv
module sim_i2c1r_slave;

  localparam int HALF = 40;
  localparam int Q    = 20;

  logic       clk, rst_n;
  logic       scl_m, sda_m;
  logic [1:0] strap_a, strap_b;
  logic       sda_oe, wr_stb, wr_done, ack_done;
  logic [7:0] cfg_q;
  logic       sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  i2c1r_slave u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_bus),
    .strap_a (strap_a),
    .strap_b (strap_b),
    .sda_oe  (sda_oe),
    .cfg_q   (cfg_q),
    .wr_stb  (wr_stb),
    .wr_done (wr_done),
    .ack_done(ack_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int exp_wdone = 0, exp_adone = 0, got_wdone = 0, got_adone = 0;
  logic [7:0] sb_q[$];
  logic wd_prev = 1'b0, ad_prev = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every register load is compared with the next queued write
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        if (sb_q.size() == 0) chk("R5", "unexpected register load", 32'(cfg_q), 32'hFFFF);
        else chk("R5", "loaded value", 32'(cfg_q), 32'(sb_q.pop_front()));
      end
      if (wr_done) got_wdone++;
      if (ack_done) got_adone++;
      if (wr_done && wd_prev) chk("R11", "wr_done width", 32'd2, 32'd1);
      if (ack_done && ad_prev) chk("R11", "ack_done width", 32'd2, 32'd1);
      wd_prev = wr_done;
      ad_prev = ack_done;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_dut(input logic [1:0] a, input logic [1:0] b);
    @(negedge clk);
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    strap_a = a; strap_b = b;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    chk("R10", "register after reset", 32'(cfg_q), 32'hE1);
    chk("R10", "sda released after reset", 32'(sda_oe), 32'd0);
  endtask

  task automatic m_start;
    sda_m = 1'b1; wait_n(Q);
    scl_m = 1'b1; wait_n(Q);
    sda_m = 1'b0; wait_n(Q);
    scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; wait_n(Q);
    scl_m = 1'b1; wait_n(Q);
    sda_m = 1'b1; wait_n(Q);
  endtask

  task automatic m_wbit(input logic b, input bit g);
    sda_m = b;
    wait_n(8);
    if (g) begin scl_m = 1'b1; wait_n(3); scl_m = 1'b0; end
    wait_n(12);
    scl_m = 1'b1;
    wait_n(15);
    if (g && !b) begin sda_m = 1'b1; wait_n(3); sda_m = 1'b0; end
    wait_n(25);
    scl_m = 1'b0;
    wait_n(Q);
  endtask

  task automatic m_rbit(output logic b);
    sda_m = 1'b1; wait_n(Q);
    scl_m = 1'b1; wait_n(HALF - 2);
    b = sda_bus;
    wait_n(2);
    scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic m_byte_w(input logic [7:0] d, input bit g, output logic ack);
    for (int i = 7; i >= 0; i--) m_wbit(d[i], g);
    m_rbit(ack);
  endtask

  task automatic m_byte_r(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) m_rbit(d[i]);
    m_wbit(mack, 1'b0);
  endtask

  task automatic wr_xfer(input logic [6:0] a, input bit exp_ack, input int n,
                         input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                         input bit g, input string req);
    logic ack;
    logic [7:0] d;
    m_start;
    m_byte_w({a, 1'b0}, 1'b0, ack);
    chk(req, "address acknowledge", 32'(ack), exp_ack ? 32'd0 : 32'd1);
    if (exp_ack) begin
      exp_adone++;
      for (int i = 0; i < n; i++) begin
        d = (i == 0) ? d0 : ((i == 1) ? d1 : d2);
        sb_q.push_back(d);
        exp_wdone++;
        exp_adone++;
        m_byte_w(d, g, ack);
        chk(req, "data acknowledge", 32'(ack), 32'd0);
      end
    end
    m_stop;
    wait_n(Q);
  endtask

  task automatic rd_xfer(input logic [6:0] a, input int n, input logic [7:0] exp);
    logic ack;
    logic [7:0] d;
    m_start;
    m_byte_w({a, 1'b1}, 1'b0, ack);
    chk("R7", "read address acknowledge", 32'(ack), 32'd0);
    exp_adone++;
    for (int i = 0; i < n; i++) begin
      m_byte_r((i == n - 1) ? 1'b1 : 1'b0, d);
      chk("R7", "read data", 32'(d), 32'(exp));
    end
    m_rbit(ack);
    chk("R7", "sda released after host nack", 32'(ack), 32'd1);
    m_stop;
    wait_n(Q);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    rst_n = 1'b1; scl_m = 1'b1; sda_m = 1'b1; strap_a = 2'b10; strap_b = 2'b10;
    wait_n(2);
    reset_dut(2'b10, 2'b10);                                   // R10, address 0x60

    wr_xfer(7'h60, 1'b1, 1, 8'h3C, 8'h00, 8'h00, 1'b0, "R2");  // R2 R5 R11
    chk("R5", "register port", 32'(cfg_q), 32'h3C);
    rd_xfer(7'h60, 1, 8'h3C);                                  // R7 single byte
    rd_xfer(7'h60, 2, 8'h3C);                                  // R7 resend after host ack

    wr_xfer(7'h60, 1'b1, 3, 8'h11, 8'h22, 8'h9F, 1'b0, "R6");  // R6 overwrite
    chk("R6", "last byte kept", 32'(cfg_q), 32'h9F);

    wr_xfer(7'h61, 1'b0, 1, 8'h00, 8'h00, 8'h00, 1'b0, "R2");  // R2 mismatch
    chk("R2", "register untouched by other address", 32'(cfg_q), 32'h9F);

    // R1: clocks without START
    scl_m = 1'b0; wait_n(Q);
    for (int i = 7; i >= 0; i--) m_wbit(8'hC0 >> i, 1'b0);
    m_rbit(ack);
    chk("R1", "no acknowledge without start", 32'(ack), 32'd1);
    m_stop; wait_n(Q);

    // R8: STOP in mid byte
    m_start;
    m_byte_w({7'h60, 1'b0}, 1'b0, ack);
    chk("R8", "address acknowledge", 32'(ack), 32'd0);
    exp_adone++;
    m_wbit(1'b1, 1'b0); m_wbit(1'b0, 1'b0); m_wbit(1'b1, 1'b0); m_wbit(1'b0, 1'b0);
    m_stop; wait_n(Q);
    chk("R8", "partial byte discarded on stop", 32'(cfg_q), 32'h9F);

    // R8: START in mid byte, then a full write in the new address phase
    m_start;
    m_byte_w({7'h60, 1'b0}, 1'b0, ack);
    exp_adone++;
    m_wbit(1'b0, 1'b0); m_wbit(1'b0, 1'b0); m_wbit(1'b0, 1'b0);
    chk("R8", "register before restart", 32'(cfg_q), 32'h9F);
    m_start;
    m_byte_w({7'h60, 1'b0}, 1'b0, ack);
    chk("R8", "address acknowledge after restart", 32'(ack), 32'd0);
    exp_adone++;
    sb_q.push_back(8'hA5); exp_wdone++; exp_adone++;
    m_byte_w(8'hA5, 1'b0, ack);
    chk("R8", "data acknowledge after restart", 32'(ack), 32'd0);
    m_stop; wait_n(Q);
    chk("R8", "write after restart", 32'(cfg_q), 32'hA5);

    // R9: short spikes on both lines during a write
    wr_xfer(7'h60, 1'b1, 1, 8'h5A, 8'h00, 8'h00, 1'b1, "R9");
    chk("R9", "value despite spikes", 32'(cfg_q), 32'h5A);

    // R3: low/low selects 0x68, strap changes after reset ignored
    reset_dut(2'b00, 2'b00);
    strap_a = 2'b10; strap_b = 2'b10;
    wr_xfer(7'h60, 1'b0, 1, 8'h00, 8'h00, 8'h00, 1'b0, "R3");
    wr_xfer(7'h68, 1'b1, 1, 8'h77, 8'h00, 8'h00, 1'b0, "R3");
    chk("R3", "write through latched address", 32'(cfg_q), 32'h77);

    // R4: reserved entry and illegal code
    reset_dut(2'b10, 2'b01);
    wr_xfer(7'h60, 1'b0, 1, 8'h00, 8'h00, 8'h00, 1'b0, "R4");
    wr_xfer(7'h64, 1'b0, 1, 8'h00, 8'h00, 8'h00, 1'b0, "R4");
    reset_dut(2'b11, 2'b10);
    wr_xfer(7'h60, 1'b0, 1, 8'h00, 8'h00, 8'h00, 1'b0, "R4");
    chk("R4", "register unchanged", 32'(cfg_q), 32'hE1);

    wait_n(10);
    chk("R11", "wr_done count", 32'(got_wdone), 32'(exp_wdone));
    chk("R11", "ack_done count", 32'(got_adone), 32'(exp_adone));
    chk("R5", "scoreboard drained", 32'(sb_q.size()), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule